// File: doc/BRIEF.md
# Hardware/Software Cross-Call Controller

This controller arbitrates procedure calls between a host processor and a set of accelerator units. Software starts an accelerator by writing a call command that names it; the accelerator in turn may call a software function, or another accelerator, through the controller. Only one accelerator runs at any time. Every other caller in the chain waits on a small last-in, first-out caller stack until its callee returns.

The processor sees eight word registers: four shared argument registers, a stack-pointer register, a return-address register, an interrupt status register and a command register. The stack-pointer value is driven to the accelerators so that arguments beyond the fourth can be fetched from memory at that address. An interrupt reports either that an accelerator finished a call made by software, or that an accelerator is asking for a software function; in the second case the status also holds the callee number. The accelerators receive one-cycle start pulses and the register values. They return single-cycle finish strobes and one shared request bus.

Top module: `xcall_ctrl`

## Requirements
- R1: After synchronous reset, every register reads zero, `acc_start` is zero and `irq` is low.
- R2: Host writes to addresses 0..3 (arguments), 4 (stack pointer) and 5 (return address) are stored. A read returns the addressed register on `host_rdata` one cycle later. The four arguments, the stack pointer and the return address also drive `arg_flat`, `sp_out` and `link_out`.
- R3: A write to address 7 with `wdata[1:0]`=01 is a call command, and the target number sits in `wdata[7:4]`. When no accelerator is running, a valid target k (1..N_ACC) gets exactly `acc_start[k-1]` high for the single cycle after the write.
- R4: When an accelerator started by software raises its `acc_done` bit, status bit 0 (hardware finished) is set and `irq` is high from the next cycle.
- R5: A request from the running accelerator with `acc_req_sw`=1 and a non-zero `acc_req_id` suspends it. It stores `acc_req_ret` in the return-address register, sets status bit 1 and puts the callee number in status bits 7:4. It raises `irq` and pulses no start.
- R6: A write to address 7 with `wdata[1:0]`=10 (software finish) while an accelerator is suspended on software restarts that accelerator with a one-cycle start pulse. In any other state it has no effect.
- R7: A request with `acc_req_sw`=0 and a valid target starts the target. When the target finishes, the caller is started again and no interrupt is raised.
- R8: A call or hardware request naming target 0, or a target above N_ACC, is ignored: no start, no error bit.
- R9: The caller stack holds 4 entries and returns in last-in, first-out order. A call that would push onto a full stack is not carried out and sets status bit 9 (overflow).
- R10: A valid call command while an accelerator is running sets status bit 8 (busy error) and starts nothing.
- R11: Writing address 6 clears status bits by writing one: bit 0 clears hardware finished, bit 1 clears the software request and the callee number, and bits 8 and 9 clear the error flags. `irq` is high exactly while bit 0 or bit 1 is set.
- R12: A software function that runs while an accelerator is suspended may call another accelerator. When that accelerator finishes, the processor gets the hardware-finished interrupt and the suspended accelerator stays suspended until the software-finish command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt to processor |
| arg_flat | output | 4*DATA_W | Argument registers, argument 0 in the low word |
| sp_out | output | DATA_W | Stack pointer for memory-passed arguments |
| link_out | output | DATA_W | Return-address register |
| acc_start | output | N_ACC | One-cycle start pulse per accelerator |
| acc_done | input | N_ACC | Finish strobe per accelerator |
| acc_req_valid | input | 1 | Call request from the running accelerator |
| acc_req_sw | input | 1 | Request targets software (1) or hardware (0) |
| acc_req_id | input | 4 | Callee number |
| acc_req_ret | input | DATA_W | Return point of the requesting accelerator |

## Verification
The properties assume that only the running accelerator drives `acc_done` or the request bus, and that those inputs are single-cycle strobes. They also assume the processor never writes a command and an acknowledge in the same cycle. The stimulus follows a plain call protocol: it raises a finish or a request only for the accelerator it has just seen started, it holds every strobe for exactly one cycle, and it lets irq-acknowledge writes settle before the next event. Within those rules the reference model follows every state the controller can reach, including a full stack and calls nested across software.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int XC_ID_W   = 4;
  localparam int XC_ADDR_W = 3;
  localparam logic [XC_ADDR_W-1:0] A_SP   = 3'd4;
  localparam logic [XC_ADDR_W-1:0] A_LINK = 3'd5;
  localparam logic [XC_ADDR_W-1:0] A_STAT = 3'd6;
  localparam logic [XC_ADDR_W-1:0] A_CMD  = 3'd7;
  localparam int ST_HWFIN = 0;
  localparam int ST_SWREQ = 1;
  localparam int ST_ID_LSB = 4;
  localparam int ST_BUSY  = 8;
  localparam int ST_OVF   = 9;
  localparam logic [1:0] OP_CALL  = 2'b01;
  localparam logic [1:0] OP_SWFIN = 2'b10;
  typedef enum logic [1:0] {XC_IDLE, XC_RUN, XC_SWWAIT} xc_state_e;
endpackage

// File: rtl/xc_callstack.sv
module xc_callstack #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [ID_W-1:0]  push_id,
  output logic [ID_W-1:0]  top_id,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full
);
  logic [ID_W-1:0]  mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign top_id = mem_q[IDX_W'(cnt_q - CNT_W'(1))];

  always_ff @(posedge clk) begin
    if (push && !full) mem_q[IDX_W'(cnt_q)] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (push && !full) cnt_q <= cnt_q + CNT_W'(1);
    else if (pop && !empty) cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/xc_hostregs.sv
module xc_hostregs
  import xc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [XC_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 link_we,
  input  logic [DATA_W-1:0]    link_val,
  input  logic                 set_hwfin,
  input  logic                 set_swreq,
  input  logic [XC_ID_W-1:0]   swreq_id,
  input  logic                 set_busy,
  input  logic                 set_ovf,
  output logic [DATA_W-1:0]    rdata,
  output logic [4*DATA_W-1:0]  arg_flat,
  output logic [DATA_W-1:0]    sp,
  output logic [DATA_W-1:0]    link,
  output logic                 hwfin_q,
  output logic                 swreq_q,
  output logic                 busy_q,
  output logic                 ovf_q,
  output logic                 irq
);
  logic [DATA_W-1:0]  arg_q [4];
  logic [XC_ID_W-1:0] swid_q;
  logic [DATA_W-1:0]  stat_w;
  logic               ack;

  assign ack = we && (addr == A_STAT);
  assign irq = hwfin_q | swreq_q;

  for (genvar g = 0; g < 4; g++) begin : g_arg
    assign arg_flat[g*DATA_W +: DATA_W] = arg_q[g];
    always_ff @(posedge clk) begin
      if (rst) arg_q[g] <= '0;
      else if (we && addr == XC_ADDR_W'(g)) arg_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp   <= '0;
      link <= '0;
    end else begin
      if (we && addr == A_SP) sp <= wdata;
      if (link_we) link <= link_val;
      else if (we && addr == A_LINK) link <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hwfin_q <= 1'b0;
      swreq_q <= 1'b0;
      swid_q  <= '0;
      busy_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (ack && wdata[ST_HWFIN]) hwfin_q <= 1'b0;
      if (ack && wdata[ST_SWREQ]) begin
        swreq_q <= 1'b0;
        swid_q  <= '0;
      end
      if (ack && wdata[ST_BUSY]) busy_q <= 1'b0;
      if (ack && wdata[ST_OVF])  ovf_q  <= 1'b0;
      if (set_hwfin) hwfin_q <= 1'b1;
      if (set_swreq) begin
        swreq_q <= 1'b1;
        swid_q  <= swreq_id;
      end
      if (set_busy) busy_q <= 1'b1;
      if (set_ovf)  ovf_q  <= 1'b1;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[ST_HWFIN] = hwfin_q;
    stat_w[ST_SWREQ] = swreq_q;
    stat_w[ST_ID_LSB +: XC_ID_W] = swid_q;
    stat_w[ST_BUSY] = busy_q;
    stat_w[ST_OVF]  = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        3'd0, 3'd1, 3'd2, 3'd3: rdata <= arg_q[addr[1:0]];
        A_SP:   rdata <= sp;
        A_LINK: rdata <= link;
        A_STAT: rdata <= stat_w;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xc_seq.sv
module xc_seq
  import xc_pkg::*;
#(
  parameter int N_ACC = 4,
  parameter int CNT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_call,
  input  logic               cmd_swfin,
  input  logic [XC_ID_W-1:0] cmd_id,
  input  logic [N_ACC-1:0]   acc_done,
  input  logic               req_valid,
  input  logic               req_sw,
  input  logic [XC_ID_W-1:0] req_id,
  input  logic [XC_ID_W-1:0] st_top,
  input  logic [CNT_W-1:0]   st_cnt,
  input  logic               st_empty,
  input  logic               st_full,
  output logic               st_push,
  output logic               st_pop,
  output logic [XC_ID_W-1:0] st_push_id,
  output logic               link_we,
  output logic               set_hwfin,
  output logic               set_swreq,
  output logic               set_busy,
  output logic               set_ovf,
  output logic [N_ACC-1:0]   acc_start
);
  xc_state_e          state_q, state_n;
  logic [XC_ID_W-1:0] act_q, act_n;
  logic [N_ACC-1:0]   start_n;
  logic               call_ok, req_go, done_hit;

  function automatic logic [N_ACC-1:0] onehot_of(input logic [XC_ID_W-1:0] id);
    logic [N_ACC-1:0] v;
    v = '0;
    for (int i = 0; i < N_ACC; i++) if (id == XC_ID_W'(i + 1)) v[i] = 1'b1;
    return v;
  endfunction

  assign call_ok  = cmd_call && (onehot_of(cmd_id) != '0);
  assign req_go   = req_valid && (req_sw ? (req_id != '0) : (onehot_of(req_id) != '0));
  assign done_hit = |(acc_done & onehot_of(act_q));

  always_comb begin
    state_n    = state_q;
    act_n      = act_q;
    start_n    = '0;
    st_push    = 1'b0;
    st_pop     = 1'b0;
    st_push_id = '0;
    link_we    = 1'b0;
    set_hwfin  = 1'b0;
    set_swreq  = 1'b0;
    set_busy   = 1'b0;
    set_ovf    = 1'b0;
    case (state_q)
      XC_IDLE: if (call_ok) begin
        act_n   = cmd_id;
        start_n = onehot_of(cmd_id);
        state_n = XC_RUN;
      end
      XC_RUN: begin
        set_busy = call_ok;
        if (done_hit) begin
          if (st_empty || st_top == '0) begin
            st_pop    = !st_empty;
            set_hwfin = 1'b1;
            act_n     = '0;
            state_n   = (st_cnt > CNT_W'(1)) ? XC_SWWAIT : XC_IDLE;
          end else begin
            st_pop  = 1'b1;
            act_n   = st_top;
            start_n = onehot_of(st_top);
          end
        end else if (req_go) begin
          if (st_full) set_ovf = 1'b1;
          else begin
            st_push    = 1'b1;
            st_push_id = act_q;
            if (req_sw) begin
              link_we   = 1'b1;
              set_swreq = 1'b1;
              act_n     = '0;
              state_n   = XC_SWWAIT;
            end else begin
              act_n   = req_id;
              start_n = onehot_of(req_id);
            end
          end
        end
      end
      XC_SWWAIT: begin
        if (cmd_swfin) begin
          st_pop  = 1'b1;
          act_n   = st_top;
          start_n = onehot_of(st_top);
          state_n = XC_RUN;
        end else if (call_ok) begin
          if (st_full) set_ovf = 1'b1;
          else begin
            st_push = 1'b1;
            act_n   = cmd_id;
            start_n = onehot_of(cmd_id);
            state_n = XC_RUN;
          end
        end
      end
      default: state_n = XC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= XC_IDLE;
      act_q     <= '0;
      acc_start <= '0;
    end else begin
      state_q   <= state_n;
      act_q     <= act_n;
      acc_start <= start_n;
    end
  end
endmodule

// File: rtl/xcall_ctrl.sv
module xcall_ctrl
  import xc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int N_ACC     = 4,
  parameter int STK_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_we,
  input  logic [2:0]           host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 irq,
  output logic [4*DATA_W-1:0]  arg_flat,
  output logic [DATA_W-1:0]    sp_out,
  output logic [DATA_W-1:0]    link_out,
  output logic [N_ACC-1:0]     acc_start,
  input  logic [N_ACC-1:0]     acc_done,
  input  logic                 acc_req_valid,
  input  logic                 acc_req_sw,
  input  logic [3:0]           acc_req_id,
  input  logic [DATA_W-1:0]    acc_req_ret
);
  localparam int CNT_W = $clog2(STK_DEPTH + 1);

  logic               cmd_call, cmd_swfin;
  logic               st_push, st_pop, st_empty, st_full;
  logic [XC_ID_W-1:0] st_push_id, st_top;
  logic [CNT_W-1:0]   st_cnt;
  logic               link_we, set_hwfin, set_swreq, set_busy, set_ovf;
  logic               hwfin_q, swreq_q, busy_q, ovf_q;

  assign cmd_call  = host_we && host_addr == A_CMD && host_wdata[1:0] == OP_CALL;
  assign cmd_swfin = host_we && host_addr == A_CMD && host_wdata[1:0] == OP_SWFIN;

  xc_callstack #(.ID_W(XC_ID_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(st_push), .pop(st_pop), .push_id(st_push_id),
    .top_id(st_top), .cnt(st_cnt), .empty(st_empty), .full(st_full)
  );

  xc_seq #(.N_ACC(N_ACC), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_call(cmd_call), .cmd_swfin(cmd_swfin),
    .cmd_id(host_wdata[ST_ID_LSB +: XC_ID_W]), .acc_done(acc_done),
    .req_valid(acc_req_valid), .req_sw(acc_req_sw), .req_id(acc_req_id),
    .st_top(st_top), .st_cnt(st_cnt), .st_empty(st_empty), .st_full(st_full),
    .st_push(st_push), .st_pop(st_pop), .st_push_id(st_push_id),
    .link_we(link_we), .set_hwfin(set_hwfin), .set_swreq(set_swreq),
    .set_busy(set_busy), .set_ovf(set_ovf), .acc_start(acc_start)
  );

  xc_hostregs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .link_we(link_we), .link_val(acc_req_ret),
    .set_hwfin(set_hwfin), .set_swreq(set_swreq), .swreq_id(acc_req_id),
    .set_busy(set_busy), .set_ovf(set_ovf),
    .rdata(host_rdata), .arg_flat(arg_flat), .sp(sp_out), .link(link_out),
    .hwfin_q(hwfin_q), .swreq_q(swreq_q), .busy_q(busy_q), .ovf_q(ovf_q),
    .irq(irq)
  );
endmodule

// File: rtl/xc_ctrl_chk.sv
module xc_ctrl_chk #(
  parameter int DATA_W    = 32,
  parameter int N_ACC     = 4,
  parameter int STK_DEPTH = 4,
  localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [2:0]        host_addr,
  input logic [N_ACC-1:0]  acc_start,
  input logic [N_ACC-1:0]  acc_done,
  input logic [DATA_W-1:0] acc_req_ret,
  input logic [DATA_W-1:0] link_out,
  input logic              hwfin_q,
  input logic              swreq_q,
  input logic              busy_q,
  input logic              ovf_q,
  input logic [CNT_W-1:0]  st_cnt
);
  assert_start_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc_start));
  assert_link_saved_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(swreq_q) |-> link_out == $past(acc_req_ret));
  assert_hwfin_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(hwfin_q) |-> $past(|acc_done));
  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(host_we && host_addr == 3'd7));
  assert_stack_bound_R9: assert property (@(posedge clk) disable iff (rst)
    st_cnt <= CNT_W'(STK_DEPTH));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $stable(st_cnt));
endmodule

bind xcall_ctrl xc_ctrl_chk #(.DATA_W(DATA_W), .N_ACC(N_ACC), .STK_DEPTH(STK_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .acc_start(acc_start), .acc_done(acc_done), .acc_req_ret(acc_req_ret),
  .link_out(link_out), .hwfin_q(hwfin_q), .swreq_q(swreq_q), .busy_q(busy_q),
  .ovf_q(ovf_q), .st_cnt(st_cnt)
);

// File: tb/test_xcall_ctrl.sv
module test_xcall_ctrl;
  localparam int DW = 32;
  localparam int NA = 4;

  logic clk = 0, rst = 1;
  logic host_we = 0;
  logic [2:0] host_addr = 0;
  logic [DW-1:0] host_wdata = 0;
  logic [DW-1:0] host_rdata, sp_out, link_out;
  logic irq;
  logic [4*DW-1:0] arg_flat;
  logic [NA-1:0] acc_start;
  logic [NA-1:0] acc_done = 0;
  logic acc_req_valid = 0, acc_req_sw = 0;
  logic [3:0] acc_req_id = 0;
  logic [DW-1:0] acc_req_ret = 0;

  xcall_ctrl #(.DATA_W(DW), .N_ACC(NA), .STK_DEPTH(4)) i_xcall_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state
  int mst = 0, mact = 0;
  int stk[$];
  logic [DW-1:0] marg[4], msp, mlink, exp_rdata;
  bit mh, ms, mb, mo;
  logic [3:0] mid;
  logic [NA-1:0] exp_start;

  function automatic bit idok(int x);
    return x >= 1 && x <= NA;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mst = 0; mact = 0; stk.delete();
      for (int i = 0; i < 4; i++) marg[i] = 0;
      msp = 0; mlink = 0; mh = 0; ms = 0; mb = 0; mo = 0; mid = 0;
      exp_start = 0; exp_rdata = 0;
    end else begin
      bit call, swfin, ack, linkev, sh, ss, sb, so;
      int cid, nst, rid;
      logic [DW-1:0] sw;
      sw = {22'b0, mo, mb, mid, 2'b00, ms, mh};
      case (host_addr)
        0, 1, 2, 3: exp_rdata = marg[host_addr[1:0]];
        4: exp_rdata = msp;
        5: exp_rdata = mlink;
        6: exp_rdata = sw;
        default: exp_rdata = 0;
      endcase
      call  = host_we && host_addr == 7 && host_wdata[1:0] == 2'b01;
      swfin = host_we && host_addr == 7 && host_wdata[1:0] == 2'b10;
      ack   = host_we && host_addr == 6;
      cid = int'(host_wdata[7:4]);
      rid = int'(acc_req_id);
      nst = 0; linkev = 0; sh = 0; ss = 0; sb = 0; so = 0;
      if (mst == 0) begin
        if (call && idok(cid)) begin mact = cid; nst = cid; mst = 1; end
      end else if (mst == 1) begin
        if (call && idok(cid)) sb = 1;
        if (mact > 0 && acc_done[mact-1]) begin
          if (stk.size() == 0 || stk[$] == 0) begin
            if (stk.size() > 0) void'(stk.pop_back());
            sh = 1; mact = 0;
            mst = (stk.size() > 0) ? 2 : 0;
          end else begin
            mact = stk.pop_back(); nst = mact;
          end
        end else if (acc_req_valid && (acc_req_sw ? rid != 0 : idok(rid))) begin
          if (stk.size() == 4) so = 1;
          else begin
            stk.push_back(mact);
            if (acc_req_sw) begin
              linkev = 1; ss = 1; mact = 0; mst = 2;
            end else begin
              mact = rid; nst = rid;
            end
          end
        end
      end else begin
        if (swfin) begin
          mact = stk.pop_back(); nst = mact; mst = 1;
        end else if (call && idok(cid)) begin
          if (stk.size() == 4) so = 1;
          else begin stk.push_back(0); mact = cid; nst = cid; mst = 1; end
        end
      end
      if (host_we && host_addr < 4) marg[host_addr[1:0]] = host_wdata;
      if (host_we && host_addr == 4) msp = host_wdata;
      if (linkev) mlink = acc_req_ret;
      else if (host_we && host_addr == 5) mlink = host_wdata;
      if (ack) begin
        if (host_wdata[0]) mh = 0;
        if (host_wdata[1]) begin ms = 0; mid = 0; end
        if (host_wdata[8]) mb = 0;
        if (host_wdata[9]) mo = 0;
      end
      if (sh) mh = 1;
      if (ss) begin ms = 1; mid = acc_req_id; end
      if (sb) mb = 1;
      if (so) mo = 1;
      exp_start = (nst > 0) ? NA'(1 << (nst - 1)) : '0;
    end
  end

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("acc_start", DW'(acc_start), DW'(exp_start));
      chk("irq", DW'(irq), DW'(mh | ms));
      chk("host_rdata", host_rdata, exp_rdata);
      chk("link_out", link_out, mlink);
      chk("sp_out", sp_out, msp);
      chk("arg0", arg_flat[DW-1:0], marg[0]);
    end
  end

  task automatic hwr(logic [2:0] a, logic [DW-1:0] d);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0; host_wdata = 0;
  endtask
  task automatic call_id(int id);
    hwr(3'd7, DW'((id << 4) | 1));
  endtask
  task automatic done(int id);
    acc_done = NA'(1 << (id - 1));
    @(negedge clk);
    acc_done = 0;
  endtask
  task automatic req(bit sw, int id, logic [DW-1:0] ret);
    acc_req_valid = 1; acc_req_sw = sw; acc_req_id = 4'(id); acc_req_ret = ret;
    @(negedge clk);
    acc_req_valid = 0; acc_req_sw = 0; acc_req_id = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic look(logic [2:0] a);
    host_addr = a; idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1"; look(3'd6); look(3'd5);
    cur_req = "R2";
    for (int i = 0; i < 6; i++) hwr(3'(i), 32'hA000_0000 + i * 32'h111);
    for (int i = 0; i < 6; i++) look(3'(i));
    host_addr = 3'd6;
    cur_req = "R3"; call_id(2); idle(1);
    cur_req = "R4"; done(2); idle(2);
    cur_req = "R11"; hwr(3'd6, 32'h1); idle(2);
    cur_req = "R8"; call_id(0); call_id(7); idle(2); req(0, 0, 0); idle(1);
    cur_req = "R10"; call_id(1); idle(1); call_id(3); idle(2);
    cur_req = "R11"; hwr(3'd6, 32'h100); idle(2);
    cur_req = "R5"; req(1, 9, 32'h1234_5678); idle(2); look(3'd5); look(3'd6);
    cur_req = "R11"; hwr(3'd6, 32'h2); idle(2);
    cur_req = "R12"; call_id(3); idle(1); done(3); idle(2); hwr(3'd6, 32'h1); idle(1);
    cur_req = "R6"; hwr(3'd0, 32'hBEEF); hwr(3'd7, 32'h2); idle(2);
    cur_req = "R7"; req(0, 4, 32'h44); idle(1); done(4); idle(2); done(1); idle(2);
    hwr(3'd6, 32'h303); idle(1);
    cur_req = "R6"; hwr(3'd7, 32'h2); idle(2);
    cur_req = "R9"; call_id(1); req(0, 2, 0); req(0, 3, 0); req(0, 4, 0); req(0, 1, 0);
    req(0, 2, 0); idle(2); look(3'd6);
    done(1); done(4); done(3); done(2); idle(1); done(1); idle(2);
    cur_req = "R11"; hwr(3'd6, 32'h303); idle(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule